// File: doc/BRIEF.md
# Receiver Mode Control and Interrupt Routing

This block decides, from two mode pins, which detector of a line-signal receiver is reported on the shared detect output and which events may pull the shared active-low interrupt. A "zero-power" pin, when high, puts the receiver into a standby state. In standby only the ring/line-reversal detector and the output drivers stay alive. When that pin is low, a second pin chooses between dual-tone alert detection and FSK data reception. The block also produces enables that power down the analogue front end (amplifier, band filter and oscillator), the tone-alert detector and the FSK receive path.

The analogue detectors are outside the block and arrive as digital flags: a ring/reversal flag, a tone-alert flag, an FSK level flag and a character-ready request from the data retiming logic. All flags are synchronised before use. In tone-alert mode the interrupt reports the end of a tone burst, not its start. That interrupt is held until the controller moves the pins out of tone-alert mode, so firmware can measure the burst from the detect output and still see that it ended.

The interrupt is presented as an active-low level plus a separate output enable that is high only while the pin is pulled low, which models an open-drain pin with an external pull-up.

Top module: `mdc_ctrl`

## Requirements
- R1: While reset is asserted and after its release until the first clock edge, det_o is 0, irq_n_o is 1, irq_oe_o is 0 and all three enables are 0 (the mode register resets to zero-power with the interrupt silenced).
- R2: The mode pins are registered on each clock edge and take effect on the outputs right after that edge. The encoding {zp_pin_i, mode_pin_i} is 00 tone-alert, 01 FSK receive, 10 zero-power with ring interrupt, and 11 zero-power with no interrupt. The four flags each pass through SYNC_STAGES flip-flops (default 2) before they are used.
- R3: In tone-alert mode det_o equals the synchronised tone flag, and the interrupt is active when the synchronised ring flag is high or the tone-end latch is set.
- R4: In tone-alert mode, a falling edge of the synchronised tone flag sets the tone-end latch. The interrupt goes active after the third clock edge following the flag falling at the input. It stays active even if the tone flag rises again, as long as the mode stays tone-alert.
- R5: Leaving tone-alert mode removes the tone-end interrupt in the same cycle that the new mode is registered. Returning to tone-alert mode later does not bring it back.
- R6: In FSK receive mode det_o equals the synchronised level flag, and the interrupt is active when the synchronised retiming request or ring flag is high.
- R7: In zero-power mode det_o equals the synchronised ring flag. With mode pin 0 the interrupt follows the ring flag. With mode pin 1 the interrupt is never active. The tone, level and retiming flags have no effect in either zero-power mode.
- R8: irq_oe_o is 1 exactly when irq_n_o is 0.
- R9: en_front_o is 1 in tone-alert and FSK modes. en_tone_o is 1 only in tone-alert mode. en_fsk_o is 1 only in FSK mode. All three are 0 in zero-power.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| zp_pin_i | input | 1 | Zero-power request, high selects standby |
| mode_pin_i | input | 1 | Mode select: tone-alert (0) or FSK (1) when awake |
| ring_flag_i | input | 1 | Ring / line-reversal detector flag |
| tone_flag_i | input | 1 | Dual-tone alert detector flag |
| level_flag_i | input | 1 | FSK level detector flag |
| rtm_req_i | input | 1 | Retiming block character-ready request |
| det_o | output | 1 | Detect output from the selected detector |
| irq_n_o | output | 1 | Active-low interrupt level |
| irq_oe_o | output | 1 | Drive enable for the open-drain interrupt pin |
| en_front_o | output | 1 | Enable for amplifier, band filter and oscillator |
| en_tone_o | output | 1 | Enable for tone-alert detector |
| en_fsk_o | output | 1 | Enable for FSK demodulator, level detector and retiming |

## Verification
A mode pin change shows on every output right after the next clock edge. A flag change shows after the second edge, and a tone-end interrupt after the third edge following the tone flag's fall. The bench keeps its own record of the mode last registered and of the last two flag samples, and it takes every comparison at the falling clock edge once those registers have settled. Directed sequences place explicit checks at the second and third edge after a tone ends, and in the first cycle after tone-alert mode is left.

// File: rtl/mdc_pkg.sv
package mdc_pkg;

    typedef enum logic [1:0] {
        MD_TONE    = 2'b00,
        MD_FSK     = 2'b01,
        MD_ZP_RING = 2'b10,
        MD_ZP_OFF  = 2'b11
    } mdc_mode_e;

    localparam int unsigned FLAG_W    = 4;
    localparam int unsigned FL_RING   = 0;
    localparam int unsigned FL_TONE   = 1;
    localparam int unsigned FL_LEVEL  = 2;
    localparam int unsigned FL_RTM    = 3;

    typedef struct packed {
        logic front;
        logic tone;
        logic fsk;
    } mdc_en_t;

endpackage

// File: rtl/mdc_sync.sv
module mdc_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_comb stg_d[g] = d_i;
        end else begin : g_next
            always_comb stg_d[g] = stg_q[g-1];
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stg_q[g] <= '0;
            else         stg_q[g] <= stg_d[g];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mdc_tone_end.sv
module mdc_tone_end (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tone_mode_i,
    input  logic tone_s_i,
    output logic end_o
);
    typedef struct packed {
        logic prev;
        logic held;
    } te_state_t;

    te_state_t st_d, st_q;
    logic      fall;

    always_comb begin
        st_d      = st_q;
        fall      = st_q.prev & ~tone_s_i;
        st_d.prev = tone_s_i;
        if (tone_mode_i) st_d.held = st_q.held | fall;
        else             st_d.held = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign end_o = st_q.held;

    // R4: latch stays set while tone-alert mode holds
    a_r4_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.held && tone_mode_i) |=> st_q.held);

    // R5: latch cleared once mode is not tone-alert
    a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tone_mode_i |=> !st_q.held);

    // R4: latch only sets after a tone fall seen in tone mode
    a_r4_set_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.held) |-> ($past(tone_mode_i) && $past(st_q.prev) && !$past(tone_s_i)));
endmodule

// File: rtl/mdc_route.sv
module mdc_route
    import mdc_pkg::*;
(
    input  mdc_mode_e mode_i,
    input  logic      ring_i,
    input  logic      tone_i,
    input  logic      level_i,
    input  logic      rtm_i,
    input  logic      tone_end_i,
    output logic      det_o,
    output logic      irq_o,
    output mdc_en_t   en_o
);
    always_comb begin
        det_o = 1'b0;
        irq_o = 1'b0;
        en_o  = '0;
        unique case (mode_i)
            MD_TONE: begin
                det_o    = tone_i;
                irq_o    = ring_i | tone_end_i;
                en_o     = '{front: 1'b1, tone: 1'b1, fsk: 1'b0};
            end
            MD_FSK: begin
                det_o    = level_i;
                irq_o    = ring_i | rtm_i;
                en_o     = '{front: 1'b1, tone: 1'b0, fsk: 1'b1};
            end
            MD_ZP_RING: begin
                det_o    = ring_i;
                irq_o    = ring_i;
            end
            MD_ZP_OFF: begin
                det_o    = ring_i;
                irq_o    = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mdc_ctrl.sv
module mdc_ctrl
    import mdc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic zp_pin_i,
    input  logic mode_pin_i,
    input  logic ring_flag_i,
    input  logic tone_flag_i,
    input  logic level_flag_i,
    input  logic rtm_req_i,
    output logic det_o,
    output logic irq_n_o,
    output logic irq_oe_o,
    output logic en_front_o,
    output logic en_tone_o,
    output logic en_fsk_o
);
    typedef struct packed {
        mdc_mode_e mode;
    } ctl_state_t;

    ctl_state_t        st_d, st_q;
    logic [FLAG_W-1:0] flag_raw, flag_s;
    logic              tone_mode, tone_end, irq_act;
    mdc_en_t           en;

    assign flag_raw[FL_RING]  = ring_flag_i;
    assign flag_raw[FL_TONE]  = tone_flag_i;
    assign flag_raw[FL_LEVEL] = level_flag_i;
    assign flag_raw[FL_RTM]   = rtm_req_i;

    mdc_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (flag_raw),
        .q_o    (flag_s)
    );

    always_comb begin
        st_d      = st_q;
        st_d.mode = mdc_mode_e'({zp_pin_i, mode_pin_i});
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{mode: MD_ZP_OFF};
        else         st_q <= st_d;
    end

    assign tone_mode = (st_q.mode == MD_TONE);

    mdc_tone_end u_tone_end (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tone_mode_i (tone_mode),
        .tone_s_i    (flag_s[FL_TONE]),
        .end_o       (tone_end)
    );

    mdc_route u_route (
        .mode_i     (st_q.mode),
        .ring_i     (flag_s[FL_RING]),
        .tone_i     (flag_s[FL_TONE]),
        .level_i    (flag_s[FL_LEVEL]),
        .rtm_i      (flag_s[FL_RTM]),
        .tone_end_i (tone_end & tone_mode),
        .det_o      (det_o),
        .irq_o      (irq_act),
        .en_o       (en)
    );

    assign irq_n_o    = ~irq_act;
    assign irq_oe_o   = irq_act;
    assign en_front_o = en.front;
    assign en_tone_o  = en.tone;
    assign en_fsk_o   = en.fsk;

    // R2: mode register follows the pins one edge later
    a_r2_mode_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (st_q.mode == $past({zp_pin_i, mode_pin_i})));

    // R7: quiet standby never drives the interrupt
    a_r7_quiet_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.mode == MD_ZP_OFF) |-> (irq_n_o && !irq_oe_o));

    // R9: standby removes every enable
    a_r9_standby_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.mode[1] |-> !(en_front_o || en_tone_o || en_fsk_o));

    // R9: at most one detector enable at a time
    a_r9_one_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({en_tone_o, en_fsk_o}));

    // R5: tone-end interrupt gone on the first cycle outside tone mode
    a_r5_leave: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.mode == MD_FSK) |-> (irq_n_o == !(flag_s[FL_RING] || flag_s[FL_RTM])));
endmodule

// File: tb/sim_mdc_ctrl.sv
module sim_mdc_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic zp = 1'b1, md = 1'b1;
    logic ring = 1'b0, tone = 1'b0, lvl = 1'b0, rtm = 1'b0;
    logic det, irq_n, irq_oe, en_front, en_tone, en_fsk;

    int checks = 0;
    int errors = 0;

    // bench record of registered state, from R2 latencies
    logic [1:0] m_mode = 2'b11;
    logic [3:0] m_s1 = '0, m_s2 = '0;   // {rtm,lvl,tone,ring}
    logic       m_tp = 1'b0, m_lat = 1'b0;

    always #4 clk = ~clk;

    mdc_ctrl u0 (
        .clk_i(clk), .rst_ni(rst_n), .zp_pin_i(zp), .mode_pin_i(md),
        .ring_flag_i(ring), .tone_flag_i(tone), .level_flag_i(lvl), .rtm_req_i(rtm),
        .det_o(det), .irq_n_o(irq_n), .irq_oe_o(irq_oe),
        .en_front_o(en_front), .en_tone_o(en_tone), .en_fsk_o(en_fsk)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_det(input logic [1:0] m, input logic [3:0] s);
        case (m)
            2'b00:   return s[1];
            2'b01:   return s[2];
            default: return s[0];
        endcase
    endfunction

    function automatic logic exp_irq(input logic [1:0] m, input logic [3:0] s, input logic l);
        case (m)
            2'b00:   return s[0] | l;
            2'b01:   return s[0] | s[3];
            2'b10:   return s[0];
            default: return 1'b0;
        endcase
    endfunction

    task automatic check_all();
        string t;
        t = (m_mode == 2'b00) ? "R3" : (m_mode == 2'b01) ? "R6" : "R7";
        chk({t, " det"}, det, exp_det(m_mode, m_s2));
        chk((m_mode == 2'b00 && m_lat) ? "R4 irq" : {t, " irq"}, irq_n, ~exp_irq(m_mode, m_s2, m_lat));
        chk("R8 oe", irq_oe, ~irq_n);
        chk("R9 front", en_front, ~m_mode[1]);
        chk("R9 tone", en_tone, m_mode == 2'b00);
        chk("R9 fsk", en_fsk, m_mode == 2'b01);
    endtask

    // apply at negedge, advance one edge, update record, check at next negedge
    task automatic step(input logic z, input logic m, input logic [3:0] f);
        logic nl;
        zp = z; md = m; ring = f[0]; tone = f[1]; lvl = f[2]; rtm = f[3];
        @(posedge clk);
        nl     = (m_mode == 2'b00) ? (m_lat | (m_tp & ~m_s2[1])) : 1'b0;
        m_lat  = nl;
        m_tp   = m_s2[1];
        m_s2   = m_s1;
        m_s1   = f;
        m_mode = {z, m};
        @(negedge clk);
        check_all();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic z, m;
        logic [3:0] f;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 det", det, 1'b0);
        chk("R1 irq_n", irq_n, 1'b1);
        chk("R1 oe", irq_oe, 1'b0);
        chk("R1 en", en_front | en_tone | en_fsk, 1'b0);
        rst_n = 1'b1;
        chk("R1 det after release", det, 1'b0);

        // R2: mode change visible right after one edge
        step(1'b0, 1'b1, 4'b0000);
        chk("R2 fsk enable", en_fsk, 1'b1);

        // R4: tone burst in tone-alert mode
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 4'b0010);
        chk("R3 det high during tone", det, 1'b1);
        step(1'b0, 1'b0, 4'b0000);
        chk("R4 no irq after edge 1", irq_n, 1'b1);
        step(1'b0, 1'b0, 4'b0000);
        chk("R4 no irq after edge 2", irq_n, 1'b1);
        step(1'b0, 1'b0, 4'b0000);
        chk("R4 irq after edge 3", irq_n, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 4'b0010);
        chk("R4 irq held while tone returns", irq_n, 1'b0);
        // R5: leave to FSK, irq gone at once; return does not restore
        step(1'b0, 1'b1, 4'b0000);
        chk("R5 irq cleared on leave", irq_n, 1'b1);
        step(1'b0, 1'b0, 4'b0000);
        chk("R5 not restored on return", irq_n, 1'b1);
        step(1'b0, 1'b0, 4'b0000);
        step(1'b0, 1'b0, 4'b0000);

        // R7: quiet standby ignores every flag
        for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 4'b1111);
        chk("R7 quiet irq", irq_n, 1'b1);
        chk("R7 det ring", det, 1'b1);
        // R7: standby with ring interrupt
        step(1'b1, 1'b0, 4'b0001);
        chk("R7 ring irq", irq_n, 1'b0);
        step(1'b1, 1'b0, 4'b1110);
        step(1'b1, 1'b0, 4'b1110);
        step(1'b1, 1'b0, 4'b1110);
        chk("R7 other flags ignored", irq_n, 1'b1);
        // R6: retiming request in FSK mode
        step(1'b0, 1'b1, 4'b1000);
        step(1'b0, 1'b1, 4'b1000);
        step(1'b0, 1'b1, 4'b0000);
        chk("R6 rtm irq", irq_n, 1'b0);

        // random phase
        z = 1'b0; m = 1'b0; f = '0;
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(15) == 0) begin
                z = ($urandom_range(3) == 0);
                m = $urandom_range(1);
            end
            for (int b = 0; b < 4; b++)
                if ($urandom_range(5) == 0) f[b] = ~f[b];
            step(z, m, f);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule